// File: doc/BRIEF.md
# I2C Ten-Bit Slave Address Sequencer

This block runs the address phase of an I2C slave that answers a 10-bit address. A local host loads a compare register first with the header byte (`11110`, the two top address bits, then 0) and later with the low address byte. The block shifts each incoming byte in on the rising SCL edges and judges it on the eighth falling edge. It acknowledges only a byte that matches. After each accepted address byte it stretches SCL low and waits for the host to act. Address bytes need host action between them: an update flag is raised, and the block releases SCL only after the host writes the next compare byte.

Once both address bytes have matched, the master may send a repeated Start and then the header again with the read bit set. The block acknowledges it and clears its clock-release bit. It then holds SCL until the host has put transmit data into the buffer and set clock-release again. The block then shifts that byte out MSB first. A Stop at any point drops the addressed state and lets both lines go.

SCL and SDA levels enter through a synchronizer. The block pulls a line low by asserting `sclLow` or `sdaLow`, which gives open-drain behaviour.

Top module: `i2c10_addr_seq`

## Requirements
- R1: After reset `sclLow`, `sdaLow`, `bufFull`, `updAddr` and `irq` are 0, and `clkRelease` is 1.
- R2: A first byte after Start of the form `11110` A9 A8 0 is accepted when A9 A8 equal bits 2:1 of the compare register. The block pulls SDA low for the ninth clock, the buffer takes the byte, and `bufFull` and `updAddr` go to 1.
- R3: `irq` rises on the ninth falling SCL edge of an accepted byte and is cleared only by `irqClrEn`. If a clear and a set fall in the same cycle, `irq` stays 1.
- R4: After an accepted write-address byte, SCL stays held low while `updAddr` is 1. A compare-register write clears `updAddr`, and SCL is released on the following cycle.
- R5: `bufRdEn` clears `bufFull`. A byte load in the same cycle as a read leaves `bufFull` at 1.
- R6: The second address byte is acknowledged only when all eight bits equal the compare register. It then sets `bufFull`, `updAddr` and `irq` again and stretches SCL until the host rewrites the compare register.
- R7: A first byte with the wrong top five bits, mismatched A9 A8, or the read bit set is not acknowledged and sets no flag. Later bytes of that transaction are not acknowledged either.
- R8: After a full two-byte match, a repeated Start followed by the header with bit 0 = 1 is acknowledged. This sets `bufFull`, clears `clkRelease` and holds SCL low for as long as `clkRelease` is 0.
- R9: After release, the buffer byte is driven MSB first. SDA changes only while SCL is low and is released for the ninth clock.
- R10: A Stop releases SCL and SDA and forgets the address match. A read header that follows is not acknowledged.
- R11: A second address byte that differs from the compare register in any bit is not acknowledged and sets no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| sclIn | input | 1 | Sampled SCL line level |
| sdaIn | input | 1 | Sampled SDA line level |
| sclLow | output | 1 | 1 pulls SCL low (clock stretch) |
| sdaLow | output | 1 | 1 pulls SDA low (ACK or data 0) |
| addrWrEn | input | 1 | Host write strobe for the compare register |
| addrWrData | input | 8 | Compare byte |
| bufRdEn | input | 1 | Host buffer read strobe |
| bufRdData | output | 8 | Buffer contents |
| bufWrEn | input | 1 | Host buffer write strobe |
| bufWrData | input | 8 | Transmit byte |
| ckpWrEn | input | 1 | Host write strobe for clock-release |
| ckpWrData | input | 1 | New clock-release value |
| irqClrEn | input | 1 | Host clear of the interrupt flag |
| bufFull | output | 1 | Buffer holds an unread or unsent byte |
| updAddr | output | 1 | Host must load the next compare byte |
| irq | output | 1 | Address byte accepted |
| clkRelease | output | 1 | Clock-release bit |

## Verification
Two collisions between the bus side and the host side can happen in one cycle. In the first, the host reads the buffer in the exact cycle the eighth falling SCL edge loads a byte. In the second, the host clears the interrupt in the cycle where the ninth falling edge sets it. The bench delays its host strobes by the synchronizer depth so that each strobe lands on the same clock edge as the event it collides with. It then checks that `bufFull` and `irq` both read 1 afterwards, which shows that the set takes priority over the clear.

// File: rtl/i2c10_seq_pkg.sv
package i2c10_seq_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_RXB,
    S_ACK,
    S_STRETCH,
    S_TXGO,
    S_TXB,
    S_TXACK,
    S_IGNORE
  } seqState_t;

  typedef enum logic [1:0] {
    PH_HI,
    PH_LO,
    PH_RD
  } seqPhase_t;

  typedef struct packed {
    logic shiftIn;
    logic cntClr;
    logic cntInc;
    logic loadBuf;
    logic setUpd;
    logic setIrq;
    logic clrCkp;
    logic loadTx;
    logic shiftTx;
  } seqStrobe_t;

endpackage

// File: rtl/i2c10_bus_mon.sv
module i2c10_bus_mon #(
  parameter int SYNC_DEPTH = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic sclIn,
  input  logic sdaIn,
  output logic sclLvl,
  output logic sdaLvl,
  output logic sclRise,
  output logic sclFall,
  output logic startEv,
  output logic stopEv
);

  logic [SYNC_DEPTH-1:0] sclSh;
  logic [SYNC_DEPTH-1:0] sdaSh;
  logic sclQ;
  logic sdaQ;

  generate
    if (SYNC_DEPTH == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (!rstN) begin
          sclSh <= '1;
          sdaSh <= '1;
        end else begin
          sclSh <= sclIn;
          sdaSh <= sdaIn;
        end
      end
    end else begin : g_multi
      always_ff @(posedge clk) begin
        if (!rstN) begin
          sclSh <= '1;
          sdaSh <= '1;
        end else begin
          sclSh <= {sclSh[SYNC_DEPTH-2:0], sclIn};
          sdaSh <= {sdaSh[SYNC_DEPTH-2:0], sdaIn};
        end
      end
    end
  endgenerate

  assign sclLvl = sclSh[SYNC_DEPTH-1];
  assign sdaLvl = sdaSh[SYNC_DEPTH-1];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sclQ <= 1'b1;
      sdaQ <= 1'b1;
    end else begin
      sclQ <= sclLvl;
      sdaQ <= sdaLvl;
    end
  end

  assign sclRise = sclLvl && !sclQ;
  assign sclFall = !sclLvl && sclQ;
  assign startEv = sclLvl && sclQ && sdaQ && !sdaLvl;
  assign stopEv  = sclLvl && sclQ && !sdaQ && sdaLvl;

endmodule

// File: rtl/i2c10_seq_dp.sv
module i2c10_seq_dp
  import i2c10_seq_pkg::*;
#(
  parameter int BYTE_W = 8,
  localparam int CNT_W = $clog2(BYTE_W + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobe_t        strb,
  input  logic              sdaLvl,
  input  logic              addrWrEn,
  input  logic [BYTE_W-1:0] addrWrData,
  input  logic              bufRdEn,
  input  logic              bufWrEn,
  input  logic [BYTE_W-1:0] bufWrData,
  input  logic              ckpWrEn,
  input  logic              ckpWrData,
  input  logic              irqClrEn,
  output logic [BYTE_W-1:0] bufRdData,
  output logic [CNT_W-1:0]  bitCnt,
  output logic              hdrWrOk,
  output logic              hdrRdOk,
  output logic              loOk,
  output logic              txNext,
  output logic              bufMsb,
  output logic              bufFull,
  output logic              updAddr,
  output logic              irq,
  output logic              clkRelease
);

  localparam int TAG_W = BYTE_W - 3;
  localparam logic [TAG_W-1:0] HDR_TAG = {{(TAG_W-1){1'b1}}, 1'b0};

  logic [BYTE_W-1:0] addrReg;
  logic [BYTE_W-1:0] rxShift;
  logic [BYTE_W-1:0] bufReg;
  logic [BYTE_W-1:0] txShift;
  logic              hdrOk;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrReg <= '0;
      rxShift <= '0;
      bufReg  <= '0;
      txShift <= '0;
      bitCnt  <= '0;
    end else begin
      if (addrWrEn) addrReg <= addrWrData;
      if (strb.shiftIn) rxShift <= {rxShift[BYTE_W-2:0], sdaLvl};
      if (strb.cntClr) bitCnt <= '0;
      else if (strb.cntInc) bitCnt <= bitCnt + 1'b1;
      if (strb.loadBuf) bufReg <= rxShift;
      else if (bufWrEn) bufReg <= bufWrData;
      if (strb.loadTx) txShift <= bufReg;
      else if (strb.shiftTx) txShift <= {txShift[BYTE_W-2:0], 1'b0};
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      bufFull    <= 1'b0;
      updAddr    <= 1'b0;
      irq        <= 1'b0;
      clkRelease <= 1'b1;
    end else begin
      if (strb.loadBuf || bufWrEn) bufFull <= 1'b1;
      else if (bufRdEn || strb.loadTx) bufFull <= 1'b0;
      if (strb.setUpd) updAddr <= 1'b1;
      else if (addrWrEn) updAddr <= 1'b0;
      if (strb.setIrq) irq <= 1'b1;
      else if (irqClrEn) irq <= 1'b0;
      if (strb.clrCkp) clkRelease <= 1'b0;
      else if (ckpWrEn) clkRelease <= ckpWrData;
    end
  end

  assign hdrOk   = (rxShift[BYTE_W-1 -: TAG_W] == HDR_TAG) && (rxShift[2:1] == addrReg[2:1]);
  assign hdrWrOk = hdrOk && !rxShift[0];
  assign hdrRdOk = hdrOk && rxShift[0];
  assign loOk    = (rxShift == addrReg);
  assign txNext  = txShift[BYTE_W-2];
  assign bufMsb  = bufReg[BYTE_W-1];
  assign bufRdData = bufReg;

  a_r5_load_wins: assert property (@(posedge clk) disable iff (!rstN)
    strb.loadBuf |=> bufFull);

  a_r3_irq_set_wins: assert property (@(posedge clk) disable iff (!rstN)
    strb.setIrq |=> irq);

  a_r4_addr_write_clears: assert property (@(posedge clk) disable iff (!rstN)
    (addrWrEn && !strb.setUpd) |=> !updAddr);

endmodule

// File: rtl/i2c10_seq_ctrl.sv
module i2c10_seq_ctrl
  import i2c10_seq_pkg::*;
#(
  parameter int BYTE_W = 8,
  localparam int CNT_W = $clog2(BYTE_W + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             sclLvl,
  input  logic             sclRise,
  input  logic             sclFall,
  input  logic             startEv,
  input  logic             stopEv,
  input  logic [CNT_W-1:0] bitCnt,
  input  logic             hdrWrOk,
  input  logic             hdrRdOk,
  input  logic             loOk,
  input  logic             txNext,
  input  logic             bufMsb,
  input  logic             updAddr,
  input  logic             clkRelease,
  output seqStrobe_t       strb,
  output logic             sclLow,
  output logic             sdaLow
);

  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(BYTE_W);
  localparam logic [CNT_W-1:0] LAST_TX  = CNT_W'(BYTE_W - 1);

  seqState_t state, nState;
  seqPhase_t phase, nPhase;
  logic      matched, nMatched;
  logic      nScl, nSda;
  logic      accept;

  always_comb begin
    strb     = '0;
    nState   = state;
    nPhase   = phase;
    nMatched = matched;
    nScl     = sclLow;
    nSda     = sdaLow;
    accept   = 1'b0;
    if (stopEv) begin
      nState   = S_IDLE;
      nMatched = 1'b0;
      nScl     = 1'b0;
      nSda     = 1'b0;
    end else if (startEv) begin
      nState      = S_RXB;
      nPhase      = matched ? PH_RD : PH_HI;
      strb.cntClr = 1'b1;
      nScl        = 1'b0;
      nSda        = 1'b0;
    end else begin
      case (state)
        S_RXB: begin
          if (sclRise) begin
            strb.shiftIn = 1'b1;
            strb.cntInc  = 1'b1;
          end else if (sclFall && bitCnt == FULL_CNT) begin
            case (phase)
              PH_HI:   accept = hdrWrOk;
              PH_LO:   accept = loOk;
              default: accept = hdrRdOk;
            endcase
            if (accept) begin
              strb.loadBuf = 1'b1;
              nSda         = 1'b1;
              nState       = S_ACK;
              if (phase == PH_RD) strb.clrCkp = 1'b1;
              else strb.setUpd = 1'b1;
              if (phase == PH_LO) nMatched = 1'b1;
            end else begin
              nState = S_IGNORE;
            end
          end
        end
        S_ACK: begin
          if (sclFall) begin
            nSda        = 1'b0;
            nScl        = 1'b1;
            strb.setIrq = 1'b1;
            nState      = S_STRETCH;
          end
        end
        S_STRETCH: begin
          case (phase)
            PH_HI: begin
              if (!updAddr) begin
                nScl        = 1'b0;
                strb.cntClr = 1'b1;
                nPhase      = PH_LO;
                nState      = S_RXB;
              end
            end
            PH_LO: begin
              if (!updAddr) begin
                nScl   = 1'b0;
                nState = S_IGNORE;
              end
            end
            default: begin
              if (clkRelease) begin
                strb.loadTx = 1'b1;
                strb.cntClr = 1'b1;
                nSda        = !bufMsb;
                nState      = S_TXGO;
              end
            end
          endcase
        end
        S_TXGO: begin
          nScl   = 1'b0;
          nState = S_TXB;
        end
        S_TXB: begin
          if (sclFall) begin
            if (bitCnt == LAST_TX) begin
              nSda   = 1'b0;
              nState = S_TXACK;
            end else begin
              strb.shiftTx = 1'b1;
              strb.cntInc  = 1'b1;
              nSda         = !txNext;
            end
          end
        end
        S_TXACK: begin
          if (sclFall) nState = S_IGNORE;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= S_IDLE;
      phase   <= PH_HI;
      matched <= 1'b0;
      sclLow  <= 1'b0;
      sdaLow  <= 1'b0;
    end else begin
      state   <= nState;
      phase   <= nPhase;
      matched <= nMatched;
      sclLow  <= nScl;
      sdaLow  <= nSda;
    end
  end

  a_r4_release_after_update: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_STRETCH && phase != PH_RD && !updAddr) |=> !sclLow);

  a_r8_hold_until_release: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_STRETCH && phase == PH_RD && !clkRelease) |=> sclLow);

  a_r10_stop_frees_lines: assert property (@(posedge clk) disable iff (!rstN)
    stopEv |=> (!sclLow && !sdaLow));

  a_r9_sda_moves_scl_low: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_TXB && $past(state) == S_TXB && sdaLow != $past(sdaLow)) |-> !sclLvl);

endmodule

// File: rtl/i2c10_addr_seq.sv
module i2c10_addr_seq
  import i2c10_seq_pkg::*;
#(
  parameter int BYTE_W     = 8,
  parameter int SYNC_DEPTH = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  output logic              sclLow,
  output logic              sdaLow,
  input  logic              addrWrEn,
  input  logic [BYTE_W-1:0] addrWrData,
  input  logic              bufRdEn,
  output logic [BYTE_W-1:0] bufRdData,
  input  logic              bufWrEn,
  input  logic [BYTE_W-1:0] bufWrData,
  input  logic              ckpWrEn,
  input  logic              ckpWrData,
  input  logic              irqClrEn,
  output logic              bufFull,
  output logic              updAddr,
  output logic              irq,
  output logic              clkRelease
);

  localparam int CNT_W = $clog2(BYTE_W + 1);

  logic sclLvl, sdaLvl, sclRise, sclFall, startEv, stopEv;
  logic [CNT_W-1:0] bitCnt;
  logic hdrWrOk, hdrRdOk, loOk, txNext, bufMsb;
  seqStrobe_t strb;

  i2c10_bus_mon #(.SYNC_DEPTH(SYNC_DEPTH)) i_mon (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn),
    .sclLvl(sclLvl), .sdaLvl(sdaLvl), .sclRise(sclRise), .sclFall(sclFall),
    .startEv(startEv), .stopEv(stopEv)
  );

  i2c10_seq_ctrl #(.BYTE_W(BYTE_W)) i_ctrl (
    .clk(clk), .rstN(rstN), .sclLvl(sclLvl), .sclRise(sclRise), .sclFall(sclFall),
    .startEv(startEv), .stopEv(stopEv), .bitCnt(bitCnt), .hdrWrOk(hdrWrOk),
    .hdrRdOk(hdrRdOk), .loOk(loOk), .txNext(txNext), .bufMsb(bufMsb),
    .updAddr(updAddr), .clkRelease(clkRelease), .strb(strb),
    .sclLow(sclLow), .sdaLow(sdaLow)
  );

  i2c10_seq_dp #(.BYTE_W(BYTE_W)) i_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .sdaLvl(sdaLvl),
    .addrWrEn(addrWrEn), .addrWrData(addrWrData), .bufRdEn(bufRdEn),
    .bufWrEn(bufWrEn), .bufWrData(bufWrData), .ckpWrEn(ckpWrEn),
    .ckpWrData(ckpWrData), .irqClrEn(irqClrEn), .bufRdData(bufRdData),
    .bitCnt(bitCnt), .hdrWrOk(hdrWrOk), .hdrRdOk(hdrRdOk), .loOk(loOk),
    .txNext(txNext), .bufMsb(bufMsb), .bufFull(bufFull), .updAddr(updAddr),
    .irq(irq), .clkRelease(clkRelease)
  );

endmodule

// File: tb/test_i2c10_addr_seq.sv
module test_i2c10_addr_seq;

  localparam int SD = 2;
  localparam int H  = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sclM = 1'b1, sdaM = 1'b1;
  logic sclLow, sdaLow;
  logic addrWrEn = 0, bufRdEn = 0, bufWrEn = 0, ckpWrEn = 0, ckpWrData = 0, irqClrEn = 0;
  logic [7:0] addrWrData = 0, bufWrData = 0, bufRdData;
  logic bufFull, updAddr, irq, clkRelease;
  logic sclBus, sdaBus;
  int checks = 0, fails = 0;
  bit done = 0;

  always #2 clk = ~clk;

  assign sclBus = sclM & !sclLow;
  assign sdaBus = sdaM & !sdaLow;

  i2c10_addr_seq #(.BYTE_W(8), .SYNC_DEPTH(SD)) i_i2c10_addr_seq (
    .clk(clk), .rstN(rstN), .sclIn(sclBus), .sdaIn(sdaBus),
    .sclLow(sclLow), .sdaLow(sdaLow), .addrWrEn(addrWrEn), .addrWrData(addrWrData),
    .bufRdEn(bufRdEn), .bufRdData(bufRdData), .bufWrEn(bufWrEn), .bufWrData(bufWrData),
    .ckpWrEn(ckpWrEn), .ckpWrData(ckpWrData), .irqClrEn(irqClrEn),
    .bufFull(bufFull), .updAddr(updAddr), .irq(irq), .clkRelease(clkRelease)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic wclk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic raiseScl();
    int n = 0;
    sclM = 1'b1;
    while (!sclBus && n < 5000) begin
      @(negedge clk);
      n++;
    end
    if (!sclBus) check("R4", "scl never released", 0, 1);
  endtask

  task automatic startCond();
    sdaM = 1'b1; wclk(H);
    raiseScl(); wclk(H);
    sdaM = 1'b0; wclk(H);
    sclM = 1'b0; wclk(H);
  endtask

  task automatic stopCond();
    sdaM = 1'b0; wclk(H);
    raiseScl(); wclk(H);
    sdaM = 1'b1; wclk(H);
  endtask

  task automatic hostPulse(input int which, input logic [7:0] d);
    @(negedge clk);
    case (which)
      0: begin addrWrEn = 1; addrWrData = d; end
      1: bufRdEn = 1;
      2: begin bufWrEn = 1; bufWrData = d; end
      3: begin ckpWrEn = 1; ckpWrData = d[0]; end
      default: irqClrEn = 1;
    endcase
    @(negedge clk);
    addrWrEn = 0; bufRdEn = 0; bufWrEn = 0; ckpWrEn = 0; irqClrEn = 0;
  endtask

  task automatic sendByte(input logic [7:0] b, input bit rd8, input bit clr9, output bit ack);
    for (int i = 7; i >= 0; i--) begin
      sdaM = b[i]; wclk(H);
      raiseScl(); wclk(H);
      sclM = 1'b0;
      if (i == 0 && rd8) begin
        wclk(SD); bufRdEn = 1; wclk(1); bufRdEn = 0; wclk(H - SD - 1);
      end else wclk(H);
    end
    sdaM = 1'b1; wclk(H);
    raiseScl(); wclk(H / 2);
    ack = !sdaBus;
    wclk(H / 2);
    sclM = 1'b0;
    if (clr9) begin
      wclk(SD); irqClrEn = 1; wclk(1); irqClrEn = 0; wclk(H - SD - 1);
    end else wclk(H);
  endtask

  task automatic readByte(output logic [7:0] d, output bit stable);
    logic first;
    stable = 1;
    for (int i = 7; i >= 0; i--) begin
      raiseScl(); wclk(1);
      first = sdaBus;
      wclk(H - 2);
      d[i] = sdaBus;
      if (first != d[i]) stable = 0;
      wclk(1);
      sclM = 1'b0; wclk(H);
    end
    sdaM = 1'b1; wclk(H);
    check("R9", "sda released for ninth clock", sdaLow, 0);
    raiseScl(); wclk(H);
    sclM = 1'b0; wclk(H);
  endtask

  task automatic clearHost();
    hostPulse(1, 0);
    hostPulse(4, 0);
  endtask

  task automatic tReset();
    check("R1", "sclLow", sclLow, 0);
    check("R1", "sdaLow", sdaLow, 0);
    check("R1", "bufFull", bufFull, 0);
    check("R1", "updAddr", updAddr, 0);
    check("R1", "irq", irq, 0);
    check("R1", "clkRelease", clkRelease, 1);
  endtask

  task automatic tFullReadFlow();
    bit ack, stable;
    logic [7:0] d;
    hostPulse(0, 8'hF4);
    startCond();
    sendByte(8'hF4, 0, 0, ack);
    check("R2", "header ack", ack, 1);
    check("R2", "bufFull", bufFull, 1);
    check("R2", "updAddr", updAddr, 1);
    check("R2", "buffer holds header", bufRdData, 8'hF4);
    check("R3", "irq set", irq, 1);
    check("R4", "scl stretched", sclLow, 1);
    wclk(40);
    check("R4", "still stretched", sclLow, 1);
    hostPulse(1, 0);
    check("R5", "read clears bufFull", bufFull, 0);
    hostPulse(4, 0);
    check("R3", "irq cleared", irq, 0);
    hostPulse(0, 8'hA5);
    wclk(1);
    check("R4", "updAddr cleared", updAddr, 0);
    check("R4", "scl released", sclLow, 0);
    sendByte(8'hA5, 0, 0, ack);
    check("R6", "low ack", ack, 1);
    check("R6", "updAddr again", updAddr, 1);
    check("R6", "irq again", irq, 1);
    check("R6", "scl stretched", sclLow, 1);
    clearHost();
    hostPulse(0, 8'hF4);
    wclk(1);
    check("R6", "scl released after rewrite", sclLow, 0);
    startCond();
    sendByte(8'hF5, 0, 0, ack);
    check("R8", "read header ack", ack, 1);
    check("R8", "bufFull", bufFull, 1);
    check("R8", "clkRelease cleared", clkRelease, 0);
    wclk(30);
    check("R8", "scl held", sclLow, 1);
    hostPulse(2, 8'h96);
    wclk(10);
    check("R8", "scl held before release bit", sclLow, 1);
    hostPulse(3, 8'h01);
    readByte(d, stable);
    check("R9", "tx byte MSB first", d, 8'h96);
    check("R9", "sda stable during high", stable, 1);
    stopCond();
    check("R10", "lines free after stop", {sclLow, sdaLow}, 0);
    hostPulse(4, 0);
    startCond();
    sendByte(8'hF5, 0, 0, ack);
    check("R10", "read header after stop nacked", ack, 0);
    check("R10", "no irq", irq, 0);
    stopCond();
  endtask

  task automatic tBadHeaders();
    bit ack;
    clearHost();
    startCond();
    sendByte(8'hE4, 0, 0, ack);
    check("R7", "wrong prefix nack", ack, 0);
    sendByte(8'hF4, 0, 0, ack);
    check("R7", "later byte ignored", ack, 0);
    check("R7", "no flags", {bufFull, updAddr, irq}, 0);
    stopCond();
    startCond();
    sendByte(8'hF6, 0, 0, ack);
    check("R7", "A9A8 mismatch nack", ack, 0);
    stopCond();
    startCond();
    sendByte(8'hF5, 0, 0, ack);
    check("R7", "read bit without match nack", ack, 0);
    check("R7", "no flags", {bufFull, updAddr, irq}, 0);
    stopCond();
  endtask

  task automatic tLowMismatch();
    bit ack;
    hostPulse(0, 8'hF4);
    startCond();
    sendByte(8'hF4, 0, 0, ack);
    check("R11", "header ack", ack, 1);
    clearHost();
    hostPulse(0, 8'hA5);
    sendByte(8'hA4, 0, 0, ack);
    check("R11", "low mismatch nack", ack, 0);
    check("R11", "no flags", {bufFull, updAddr, irq}, 0);
    check("R11", "no stretch", sclLow, 0);
    stopCond();
  endtask

  task automatic tCollisions();
    bit ack;
    hostPulse(0, 8'hF4);
    startCond();
    sendByte(8'hF4, 1, 1, ack);
    check("R5", "load beats read", bufFull, 1);
    check("R3", "set beats clear", irq, 1);
    clearHost();
    hostPulse(0, 8'hA5);
    wclk(4);
    stopCond();
  endtask

  initial begin
    wclk(5);
    rstN = 1'b1;
    wclk(2);
    tReset();
    tFullReadFlow();
    tBadHeaders();
    tLowMismatch();
    tCollisions();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule